// File: doc/BRIEF.md
# Error Stressing Injection Controller

This block sits beside a cell transmitter and decides, one cell at a time, whether an error condition is applied to the outgoing stream. A three-bit control selects the stressing behaviour: steady off, steady on, a single-cell pulse of either polarity, or a three-cell alternating burst of either polarity. A start request arms the next pulse or burst. When the condition is active for a cell, the block either corrupts one byte of that cell with a programmable XOR pattern or tells the transmitter to drop the cell. A dropped cell is replaced by a fill cell, and its adaptation-layer sequence number is skipped.

The transmitter presents each byte with its position in the cell, and flags the first byte with a cell-start strobe. The block samples the mode, the error kind, the target byte position and the mask on that strobe. A byte's XOR pattern comes out one clock after the byte, so the transmitter applies it in a one-stage pipeline. The cell-level flags are held from the cycle after the strobe until the cycle after the next strobe.

Top module: `err_stress_ctrl`

## Requirements
- R1: While reset is low, and right after it is released, cell_active_o, cell_drop_o, busy_o, xor_mask_o and mask_vld_o are 0. Reset clears any armed or running pulse or burst.
- R2: mode_i and the error configuration are sampled only on a cell-start beat. cell_active_o changes only in the cycle after a cell-start beat.
- R3: Mode encodings are 0 = off, 1 = on, 2 = pulse-on, 3 = pulse-off, 4 = sequence-on, 5 = sequence-off. Off makes every cell inactive and on makes every cell active. The resting level is active for modes 1, 3 and 5 and inactive for modes 0, 2 and 4.
- R4: In pulse-on mode, an accepted start makes exactly the next cell active. Cells before and after it are inactive. A start on a cell-start beat arms the following cell.
- R5: In pulse-off mode, an accepted start makes exactly the next cell inactive. Cells before and after it are active.
- R6: In sequence-on mode, an accepted start makes the next three cells active, inactive and active in turn. Later cells return to inactive.
- R7: In sequence-off mode, an accepted start makes the next three cells inactive, active and inactive in turn. Later cells return to active.
- R8: busy_o is 1 while a pulse or burst is armed or still has cells to apply. A start while busy_o is 1, or in modes 0, 1, 6 and 7, is ignored.
- R9: When err_kind_i = 0 and the cell is active, the beat whose byte_idx_i equals err_pos_i yields xor_mask_o = err_mask_i one cycle later. Every other beat yields 0. mask_vld_o is byte_valid_i delayed by one cycle.
- R10: When err_kind_i = 1 and the cell is active, cell_drop_o is 1 for that cell and xor_mask_o stays 0.
- R11: A mode change seen on a cell-start beat cancels any armed or running pulse or burst. That cell takes the new mode's resting level.
- R12: Encodings 6 and 7 behave as off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cell_start_i | input | 1 | Marks the first byte beat of a cell |
| byte_valid_i | input | 1 | A cell byte is presented this cycle |
| byte_idx_i | input | IDX_W | Position of the current byte within its cell |
| mode_i | input | 3 | Stressing mode, sampled at cell start |
| start_i | input | 1 | Request to run one pulse or burst |
| err_kind_i | input | 1 | 0 = byte corruption, 1 = cell loss |
| err_pos_i | input | IDX_W | Byte position to corrupt |
| err_mask_i | input | MASK_W | XOR pattern for the corrupted byte |
| cell_active_o | output | 1 | Error condition is active for the current cell |
| cell_drop_o | output | 1 | Replace the current cell with a fill cell and skip its sequence number |
| busy_o | output | 1 | A pulse or burst is armed or running |
| xor_mask_o | output | MASK_W | XOR pattern for the byte of the previous beat |
| mask_vld_o | output | 1 | xor_mask_o refers to a valid byte |

## Verification
The checker assumes that cell_start_i is raised only together with byte_valid_i, on the beat carrying byte index 0. It also assumes that byte indices stay below the cell length. Its properties then depend on the active level staying fixed between strobes. The bench drives every cell as one unbroken run of beats, from index 0 to the last index, with a single strobe on the first beat and an idle cycle between cells. It changes mode_i in the middle of a cell only to show that the change has no effect.

// File: rtl/err_stress_pkg.sv
package err_stress_pkg;

  typedef enum logic [2:0] {
    SM_OFF       = 3'd0,
    SM_ON        = 3'd1,
    SM_PULSE_ON  = 3'd2,
    SM_PULSE_OFF = 3'd3,
    SM_SEQ_ON    = 3'd4,
    SM_SEQ_OFF   = 3'd5
  } stress_mode_e;

  localparam int unsigned PULSE_STEPS = 1;
  localparam int unsigned SEQ_STEPS   = 3;
  localparam int unsigned STEP_W      = $clog2(SEQ_STEPS + 1);

  // level outside any pulse or burst
  function automatic logic rest_level(input logic [2:0] m);
    return (m == 3'(SM_ON)) || (m == 3'(SM_PULSE_OFF)) || (m == 3'(SM_SEQ_OFF));
  endfunction

  // cells in one burst; 0 = mode has no burst
  function automatic logic [STEP_W-1:0] burst_len(input logic [2:0] m);
    case (m)
      3'(SM_PULSE_ON), 3'(SM_PULSE_OFF): return STEP_W'(PULSE_STEPS);
      3'(SM_SEQ_ON),   3'(SM_SEQ_OFF):   return STEP_W'(SEQ_STEPS);
      default:                           return '0;
    endcase
  endfunction

endpackage

// File: rtl/err_stress_fsm.sv
module err_stress_fsm
  import err_stress_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cell_start_i,
  input  logic [2:0] mode_i,
  input  logic       start_i,
  output logic       act_now_o,
  output logic       act_q_o,
  output logic       busy_o
);

  logic [2:0]        mode_q;
  logic [STEP_W-1:0] step_q, step_d;
  logic              pend_q, pend_d;
  logic              act_q, act_d;
  logic [2:0]        eff_mode;
  logic              rest;
  logic [STEP_W-1:0] len;
  logic              mode_chg;
  logic              accept;

  assign eff_mode = cell_start_i ? mode_i : mode_q;
  assign rest     = rest_level(eff_mode);
  assign len      = burst_len(eff_mode);
  assign mode_chg = cell_start_i && (mode_i != mode_q);

  always_comb begin
    act_d  = act_q;
    step_d = step_q;
    pend_d = pend_q;
    if (cell_start_i) begin
      if (mode_chg) begin
        act_d  = rest;
        step_d = '0;
        pend_d = 1'b0;
      end else if (step_q != '0) begin
        act_d  = rest ^ step_q[0];
        step_d = (step_q == len) ? '0 : step_q + 1'b1;
      end else if (pend_q) begin
        act_d  = ~rest;
        pend_d = 1'b0;
        step_d = (len > STEP_W'(1)) ? STEP_W'(2) : '0;
      end else begin
        act_d  = rest;
      end
    end
    // a request is taken only when nothing is armed or running afterwards
    accept = start_i && (len != '0) && (step_d == '0) && !pend_d;
    if (accept) pend_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 3'(SM_OFF);
      step_q <= '0;
      pend_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      if (cell_start_i) mode_q <= mode_i;
      step_q <= step_d;
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  assign act_now_o = cell_start_i ? act_d : act_q;
  assign act_q_o   = act_q;
  assign busy_o    = pend_q || (step_q != '0);

endmodule

// File: rtl/err_cfg_hold.sv
module err_cfg_hold #(
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned MASK_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cell_start_i,
  input  logic              kind_i,
  input  logic [IDX_W-1:0]  pos_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic              kind_cur_o,
  output logic [IDX_W-1:0]  pos_cur_o,
  output logic [MASK_W-1:0] mask_cur_o,
  output logic              kind_q_o
);

  logic              kind_q;
  logic [IDX_W-1:0]  pos_q;
  logic [MASK_W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q <= 1'b0;
      pos_q  <= '0;
      mask_q <= '0;
    end else if (cell_start_i) begin
      kind_q <= kind_i;
      pos_q  <= pos_i;
      mask_q <= mask_i;
    end
  end

  // the start beat already uses the fresh settings
  assign kind_cur_o = cell_start_i ? kind_i : kind_q;
  assign pos_cur_o  = cell_start_i ? pos_i  : pos_q;
  assign mask_cur_o = cell_start_i ? mask_i : mask_q;
  assign kind_q_o   = kind_q;

endmodule

// File: rtl/err_byte_xor.sv
module err_byte_xor #(
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned MASK_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_valid_i,
  input  logic [IDX_W-1:0]  byte_idx_i,
  input  logic              act_i,
  input  logic              kind_i,
  input  logic [IDX_W-1:0]  pos_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic [MASK_W-1:0] xor_mask_o,
  output logic              mask_vld_o
);

  logic              hit;
  logic [MASK_W-1:0] xor_q;
  logic              vld_q;

  assign hit = byte_valid_i && act_i && !kind_i && (byte_idx_i == pos_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xor_q <= '0;
      vld_q <= 1'b0;
    end else begin
      xor_q <= hit ? mask_i : '0;
      vld_q <= byte_valid_i;
    end
  end

  assign xor_mask_o = xor_q;
  assign mask_vld_o = vld_q;

endmodule

// File: rtl/err_stress_ctrl.sv
module err_stress_ctrl #(
  parameter int unsigned CELL_BYTES = 53,
  parameter int unsigned MASK_W     = 8,
  localparam int unsigned IDX_W     = $clog2(CELL_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cell_start_i,
  input  logic              byte_valid_i,
  input  logic [IDX_W-1:0]  byte_idx_i,
  input  logic [2:0]        mode_i,
  input  logic              start_i,
  input  logic              err_kind_i,
  input  logic [IDX_W-1:0]  err_pos_i,
  input  logic [MASK_W-1:0] err_mask_i,
  output logic              cell_active_o,
  output logic              cell_drop_o,
  output logic              busy_o,
  output logic [MASK_W-1:0] xor_mask_o,
  output logic              mask_vld_o
);

  logic              act_now;
  logic              act_q;
  logic              kind_cur;
  logic              kind_q;
  logic [IDX_W-1:0]  pos_cur;
  logic [MASK_W-1:0] mask_cur;

  err_stress_fsm i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cell_start_i (cell_start_i),
    .mode_i       (mode_i),
    .start_i      (start_i),
    .act_now_o    (act_now),
    .act_q_o      (act_q),
    .busy_o       (busy_o)
  );

  err_cfg_hold #(.IDX_W(IDX_W), .MASK_W(MASK_W)) i_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cell_start_i (cell_start_i),
    .kind_i       (err_kind_i),
    .pos_i        (err_pos_i),
    .mask_i       (err_mask_i),
    .kind_cur_o   (kind_cur),
    .pos_cur_o    (pos_cur),
    .mask_cur_o   (mask_cur),
    .kind_q_o     (kind_q)
  );

  err_byte_xor #(.IDX_W(IDX_W), .MASK_W(MASK_W)) i_xor (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .byte_valid_i (byte_valid_i),
    .byte_idx_i   (byte_idx_i),
    .act_i        (act_now),
    .kind_i       (kind_cur),
    .pos_i        (pos_cur),
    .mask_i       (mask_cur),
    .xor_mask_o   (xor_mask_o),
    .mask_vld_o   (mask_vld_o)
  );

  assign cell_active_o = act_q;
  assign cell_drop_o   = act_q && kind_q;

endmodule

// File: rtl/err_stress_chk.sv
module err_stress_chk #(
  parameter int unsigned MASK_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cell_start_i,
  input logic [2:0]        mode_i,
  input logic              cell_active_o,
  input logic              cell_drop_o,
  input logic              busy_o,
  input logic [MASK_W-1:0] xor_mask_o,
  input logic              mask_vld_o
);

  a_r2_level_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cell_start_i |=> $stable(cell_active_o));

  a_r3_off_rest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cell_start_i && mode_i == 3'd0) |=> (!cell_active_o && !busy_o));

  a_r3_on_rest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cell_start_i && mode_i == 3'd1) |=> (cell_active_o && !busy_o));

  a_r12_bad_code_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cell_start_i && mode_i[2:1] == 2'b11) |=> (!cell_active_o && !busy_o));

  a_r8_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !cell_start_i) |=> busy_o);

  a_r9_mask_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xor_mask_o != '0) |-> (mask_vld_o && cell_active_o));

  a_r10_drop_no_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cell_drop_o |-> (xor_mask_o == '0 && cell_active_o));

endmodule

bind err_stress_ctrl err_stress_chk #(.MASK_W(MASK_W)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cell_start_i  (cell_start_i),
  .mode_i        (mode_i),
  .cell_active_o (cell_active_o),
  .cell_drop_o   (cell_drop_o),
  .busy_o        (busy_o),
  .xor_mask_o    (xor_mask_o),
  .mask_vld_o    (mask_vld_o)
);

// File: tb/test_err_stress_ctrl.sv
`timescale 1ns/1ps
module test_err_stress_ctrl;

  localparam int CELL  = 53;
  localparam int IW    = $clog2(CELL);
  localparam int NVEC  = 33;

  typedef struct packed {
    logic [2:0] mode;
    logic [2:0] mode_mid;
    logic       kind;
    logic [5:0] pos;
    logic [7:0] mask;
    logic [6:0] start_at;   // 127 = no request
    logic       exp_act;
    logic       exp_busy;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    '{3'd0,3'd0,1'b0,6'd0, 8'h00,7'd127,1'b0,1'b0,4'd3},
    '{3'd0,3'd0,1'b0,6'd3, 8'hFF,7'd10, 1'b0,1'b0,4'd8},
    '{3'd0,3'd1,1'b0,6'd3, 8'hFF,7'd127,1'b0,1'b0,4'd2},
    '{3'd1,3'd0,1'b0,6'd0, 8'h01,7'd127,1'b1,1'b0,4'd2},
    '{3'd2,3'd2,1'b0,6'd7, 8'hFF,7'd20, 1'b0,1'b1,4'd4},
    '{3'd2,3'd2,1'b0,6'd7, 8'hFF,7'd127,1'b1,1'b0,4'd4},
    '{3'd2,3'd2,1'b0,6'd7, 8'hFF,7'd127,1'b0,1'b0,4'd4},
    '{3'd3,3'd3,1'b0,6'd12,8'h55,7'd3,  1'b1,1'b1,4'd5},
    '{3'd3,3'd3,1'b0,6'd12,8'h55,7'd127,1'b0,1'b0,4'd5},
    '{3'd3,3'd3,1'b0,6'd12,8'h55,7'd127,1'b1,1'b0,4'd5},
    '{3'd4,3'd4,1'b0,6'd4, 8'h3C,7'd7,  1'b0,1'b1,4'd6},
    '{3'd4,3'd4,1'b0,6'd4, 8'h3C,7'd9,  1'b1,1'b1,4'd8},
    '{3'd4,3'd4,1'b0,6'd4, 8'h3C,7'd127,1'b0,1'b1,4'd6},
    '{3'd4,3'd4,1'b0,6'd4, 8'h3C,7'd127,1'b1,1'b0,4'd6},
    '{3'd4,3'd4,1'b0,6'd4, 8'h3C,7'd127,1'b0,1'b0,4'd6},
    '{3'd4,3'd4,1'b0,6'd4, 8'h3C,7'd127,1'b0,1'b0,4'd8},
    '{3'd5,3'd5,1'b0,6'd30,8'h80,7'd1,  1'b1,1'b1,4'd7},
    '{3'd5,3'd5,1'b0,6'd30,8'h80,7'd127,1'b0,1'b1,4'd7},
    '{3'd5,3'd5,1'b0,6'd30,8'h80,7'd127,1'b1,1'b1,4'd7},
    '{3'd5,3'd5,1'b0,6'd30,8'h80,7'd127,1'b0,1'b0,4'd7},
    '{3'd5,3'd5,1'b0,6'd30,8'h80,7'd127,1'b1,1'b0,4'd7},
    '{3'd2,3'd2,1'b1,6'd9, 8'hFF,7'd4,  1'b0,1'b1,4'd10},
    '{3'd2,3'd2,1'b1,6'd9, 8'hFF,7'd127,1'b1,1'b0,4'd10},
    '{3'd2,3'd2,1'b1,6'd9, 8'hFF,7'd127,1'b0,1'b0,4'd10},
    '{3'd4,3'd4,1'b0,6'd5, 8'h0F,7'd2,  1'b0,1'b1,4'd11},
    '{3'd4,3'd4,1'b0,6'd5, 8'h0F,7'd127,1'b1,1'b1,4'd11},
    '{3'd2,3'd2,1'b0,6'd5, 8'h0F,7'd127,1'b0,1'b0,4'd11},
    '{3'd2,3'd2,1'b0,6'd5, 8'h0F,7'd127,1'b0,1'b0,4'd11},
    '{3'd7,3'd7,1'b0,6'd5, 8'h0F,7'd5,  1'b0,1'b0,4'd12},
    '{3'd1,3'd1,1'b0,6'd52,8'hA5,7'd127,1'b1,1'b0,4'd9},
    '{3'd6,3'd1,1'b0,6'd52,8'hA5,7'd127,1'b0,1'b0,4'd12},
    '{3'd2,3'd2,1'b0,6'd1, 8'h11,7'd0,  1'b0,1'b1,4'd4},
    '{3'd2,3'd2,1'b0,6'd1, 8'h11,7'd127,1'b1,1'b0,4'd4}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cell_start = 1'b0;
  logic          byte_valid = 1'b0;
  logic [IW-1:0] byte_idx = '0;
  logic [2:0]    mode = 3'd0;
  logic          start = 1'b0;
  logic          kind = 1'b0;
  logic [IW-1:0] pos = '0;
  logic [7:0]    mask = '0;
  logic          act_o, drop_o, busy_o, vld_o;
  logic [7:0]    xor_o;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  err_stress_ctrl #(.CELL_BYTES(CELL), .MASK_W(8)) i_err_stress_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cell_start_i(cell_start), .byte_valid_i(byte_valid),
    .byte_idx_i(byte_idx), .mode_i(mode), .start_i(start), .err_kind_i(kind),
    .err_pos_i(pos), .err_mask_i(mask), .cell_active_o(act_o), .cell_drop_o(drop_o),
    .busy_o(busy_o), .xor_mask_o(xor_o), .mask_vld_o(vld_o)
  );

  function automatic string rq(input logic [3:0] n);
    case (n)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
      4'd10: return "R10"; 4'd11: return "R11"; default: return "R12";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_cell(input vec_t v);
    logic [7:0] exp_x;
    for (int b = 0; b < CELL; b++) begin
      @(negedge clk);
      cell_start = (b == 0);
      byte_valid = 1'b1;
      byte_idx   = IW'(b);
      mode       = (b == 0) ? v.mode : v.mode_mid;
      start      = (int'(v.start_at) == b);
      kind       = v.kind;
      pos        = v.pos;
      mask       = v.mask;
      @(posedge clk); #1;
      exp_x = (v.exp_act && !v.kind && b == int'(v.pos)) ? v.mask : 8'h00;
      if (b == int'(v.pos) || xor_o != exp_x)
        chk(xor_o == exp_x, "R9 xor_mask", xor_o, exp_x);
      if (!vld_o) chk(1'b0, "R9 mask_vld", vld_o, 1);
      if (b == 0) begin
        chk(act_o == v.exp_act, rq(v.req), act_o, v.exp_act);
        chk(drop_o == (v.exp_act && v.kind), "R10 drop", drop_o, v.exp_act && v.kind);
      end else if (act_o != v.exp_act) begin
        chk(1'b0, "R2 level held", act_o, v.exp_act);
      end
    end
    @(negedge clk);
    cell_start = 1'b0;
    byte_valid = 1'b0;
    start      = 1'b0;
    chk(busy_o == v.exp_busy, "R8 busy", busy_o, v.exp_busy);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk({act_o, drop_o, busy_o, vld_o, xor_o} == '0, "R1 in reset", {act_o, drop_o, busy_o, vld_o, xor_o}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk({act_o, drop_o, busy_o, vld_o, xor_o} == '0, "R1 after release", {act_o, drop_o, busy_o, vld_o, xor_o}, 0);

    for (int i = 0; i < NVEC; i++) run_cell(VEC[i]);

    // R1: reset aborts an armed pulse
    run_cell('{3'd2,3'd2,1'b0,6'd2,8'h77,7'd6,1'b0,1'b1,4'd4});
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk(!busy_o && !act_o, "R1 reset clears busy", busy_o, 0);
    @(negedge clk); rst_n = 1'b1;
    run_cell('{3'd2,3'd2,1'b0,6'd2,8'h77,7'd127,1'b0,1'b0,4'd1});
    // R5: pulse-off resting level after reset
    run_cell('{3'd3,3'd3,1'b0,6'd40,8'hC3,7'd127,1'b1,1'b0,4'd5});

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule